// File: doc/BRIEF.md
# Page Buffer and Timed Program Sequencer

This block sits between a serial-bus slave controller and a non-volatile memory array. The controller opens a write sequence with a start strobe that carries the target word address, then hands over the received data bytes one at a time. The block parks them in a small page buffer and answers each byte with an acknowledge decision on the same cycle. The upper address bits stay fixed for the page, and only the low three bits step from one byte to the next.

When the controller sees the bus stop, it pulses commit. If the buffer holds data, the sequencer enters its program cycle. It writes one buffered byte per millisecond tick through a synchronous write port, lowest slot first, and holds busy high until the last byte has been written. The controller uses busy to withhold acknowledges. A parameter selects the page behaviour. The rolling variant has eight slots, and extra bytes overwrite the oldest ones. The limited variant accepts two bytes and refuses the third, which throws away the whole sequence.

The state machine has four states. IDLE waits for a start. LOAD collects bytes. REJECT holds an aborted sequence until the next start or commit. PROG runs the program cycle. The transitions are START (IDLE, LOAD or REJECT to LOAD), ACCEPT (LOAD to LOAD), REFUSE (LOAD to REJECT), COMMIT (LOAD to PROG, buffer not empty), EMPTY (LOAD to IDLE, buffer empty), DROP (REJECT to IDLE on commit) and FINISH (PROG to IDLE on the tick that writes the last byte).

Top module: `pb_program_seq`

## Requirements
- R1: After reset, busy_o, wr_ack_o and mem_we_o are all 0.
- R2: The start strobe takes the page base from wr_addr_i[7:3] and the slot pointer from wr_addr_i[2:0]. Each accepted byte goes to the slot the pointer names, and the pointer then steps by one modulo 8, so the written address is always {base, slot}. For example, start 0x1E with three bytes fills 0x1E, 0x1F and 0x18.
- R3: With ROLLING=1, a byte whose slot is already filled replaces the old data. Each address is programmed once, with its latest data. Ten bytes from 0x80 give eight writes, with 0x80 and 0x81 holding the ninth and tenth bytes.
- R4: With ROLLING=0 and LIMIT=2, a byte arriving when two are already buffered gets wr_ack_o=0. The buffer is discarded, and the following commit starts no program cycle and causes no write.
- R5: Only commit starts a program cycle. A sequence holding one byte produces exactly one write.
- R6: Writes are spaced by the tick, one every TICK_DIV cycles. The k-th write occurs k*TICK_DIV cycles after the commit cycle, and busy_o is high for N*TICK_DIV cycles for N buffered bytes.
- R7: busy_o rises in the cycle after commit and falls in the cycle after the last write. While busy_o is high, wr_ack_o stays 0, and start strobes and bytes have no effect.
- R8: A byte presented with wr_prot_i=1 gets wr_ack_o=0, aborts the sequence including bytes already buffered, and the following commit starts no program cycle.
- R9: A commit with no buffered byte is ignored, and busy_o stays 0.
- R10: Within a program cycle, buffered slots are written in ascending slot index, so start 0x1E with three bytes writes 0x18 first, then 0x1E, then 0x1F.
- R11: A byte arriving without an open sequence (no start since the last commit or abort) gets wr_ack_o=0 and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start_i | input | 1 | Opens a write sequence; samples wr_addr_i |
| wr_addr_i | input | AW (8) | Word address of the first byte |
| wr_byte_i | input | 1 | A data byte is offered this cycle |
| wr_data_i | input | DW (8) | Offered data byte |
| wr_prot_i | input | 1 | Offered byte targets a protected location |
| wr_commit_i | input | 1 | Bus stop seen; start program cycle |
| wr_ack_o | output | 1 | Offered byte accepted (combinational) |
| busy_o | output | 1 | Program cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | AW (8) | Array write address |
| mem_data_o | output | DW (8) | Array write data |

## Verification
The bench goes after the wrap of the low address bits inside a page that starts near its top. A design that carried into the upper bits would program the next page, and one that wrote in arrival order would break the ascending write order. It overfills both variants. A rolling buffer that wrote a slot twice, or kept stale data, shows up in the write count and array contents, and a limited buffer that kept its first two bytes after refusing the third would program them. It also pushes starts and bytes into a running cycle, commits empty, protected and unopened sequences, and measures busy length against the tick count, which catches off-by-one timing and a busy flag that drops one write early.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_LOAD   = 2'd1,
        PS_REJECT = 2'd2,
        PS_PROG   = 2'd3
    } pb_state_e;

endpackage

// File: rtl/pb_tick_gen.sv
module pb_tick_gen #(
    parameter int DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick_o = run_i;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (!run_i) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick_o = run_i && (cnt_q == LAST);

            // R6: consecutive ticks are never adjacent when the divider exceeds one
            assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/pb_slot_store.sv
module pb_slot_store #(
    parameter int SLOT_BITS = 3,
    parameter int DW        = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      put_i,
    input  logic [SLOT_BITS-1:0]      put_slot_i,
    input  logic [DW-1:0]             put_data_i,
    input  logic                      take_i,
    output logic [$clog2((1<<SLOT_BITS)+1)-1:0] fill_cnt_o,
    output logic [SLOT_BITS-1:0]      head_slot_o,
    output logic [DW-1:0]             head_data_o
);
    localparam int SLOTS = 1 << SLOT_BITS;
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [SLOTS-1:0] vld_q;
    logic [DW-1:0]    dat_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < SLOTS; i++) dat_q[i] <= '0;
        end else if (clr_i) begin
            vld_q <= '0;
            for (int i = 0; i < SLOTS; i++) dat_q[i] <= '0;
        end else begin
            if (take_i) vld_q[head_slot_o] <= 1'b0;
            if (put_i) begin
                vld_q[put_slot_i] <= 1'b1;
                dat_q[put_slot_i] <= put_data_i;
            end
        end
    end

    // lowest filled slot drains first
    always_comb begin
        head_slot_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (vld_q[i]) head_slot_o = SLOT_BITS'(i);
        end
    end

    assign head_data_o = dat_q[head_slot_o];
    assign fill_cnt_o  = CNT_W'($countones(vld_q));

    // R3: a drain step always removes a slot that holds data
    assert_take_filled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (vld_q != '0));

    // R2: a store and a clear never land in the same cycle
    assert_put_clr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(put_i && clr_i));
endmodule

// File: rtl/pb_seq_fsm.sv
module pb_seq_fsm
    import pb_pkg::*;
#(
    parameter int  CNT_W   = 4,
    parameter bit  ROLLING = 1'b1,
    parameter int  LIMIT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             byte_i,
    input  logic             prot_i,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] fill_cnt_i,
    input  logic             tick_i,
    output logic             busy_o,
    output logic             ack_o,
    output logic             ptr_load_o,
    output logic             put_o,
    output logic             take_o,
    output logic             clr_o
);
    pb_state_e st_q, st_n;
    logic      overflow;
    logic      refuse;
    logic      empty;
    logic      last_one;
    logic      offer;

    generate
        if (ROLLING) begin : g_roll
            assign overflow = 1'b0;
        end else begin : g_limit
            assign overflow = (fill_cnt_i >= CNT_W'(LIMIT));
        end
    endgenerate

    assign refuse   = prot_i || overflow;
    assign empty    = (fill_cnt_i == '0);
    assign last_one = (fill_cnt_i == CNT_W'(1));
    assign offer    = (st_q == PS_LOAD) && byte_i && !start_i && !commit_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_IDLE;
        else        st_q <= st_n;
    end

    // transitions
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            PS_IDLE: begin
                if (start_i) st_n = PS_LOAD;                 // START
            end
            PS_LOAD: begin
                if (start_i)               st_n = PS_LOAD;   // START
                else if (commit_i && empty) st_n = PS_IDLE;  // EMPTY
                else if (commit_i)         st_n = PS_PROG;   // COMMIT
                else if (byte_i && refuse) st_n = PS_REJECT; // REFUSE
            end
            PS_REJECT: begin
                if (start_i)       st_n = PS_LOAD;           // START
                else if (commit_i) st_n = PS_IDLE;           // DROP
            end
            PS_PROG: begin
                if (tick_i && last_one) st_n = PS_IDLE;      // FINISH
            end
            default: st_n = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o     = (st_q == PS_PROG);
        ack_o      = offer && !refuse;
        put_o      = offer && !refuse;
        ptr_load_o = start_i && (st_q != PS_PROG);
        take_o     = (st_q == PS_PROG) && tick_i;
        clr_o      = ptr_load_o
                   || (offer && refuse)
                   || ((st_q == PS_PROG) && tick_i && last_one);
    end

    // R9: the program state is never occupied with an empty buffer
    assert_prog_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_PROG) |-> !empty);
endmodule

// File: rtl/pb_program_seq.sv
module pb_program_seq #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int SLOT_BITS = 3,
    parameter bit ROLLING   = 1'b1,
    parameter int LIMIT     = 2,
    parameter int TICK_DIV  = 250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_start_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic          wr_byte_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          wr_prot_i,
    input  logic          wr_commit_i,
    output logic          wr_ack_o,
    output logic          busy_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_data_o
);
    localparam int SLOTS  = 1 << SLOT_BITS;
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int BASE_W = AW - SLOT_BITS;

    logic [BASE_W-1:0]    base_q;
    logic [SLOT_BITS-1:0] ptr_q;
    logic [CNT_W-1:0]     fill_cnt;
    logic [SLOT_BITS-1:0] head_slot;
    logic [DW-1:0]        head_data;
    logic                 tick;
    logic                 ptr_load, put, take, clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
        end else if (ptr_load) begin
            base_q <= wr_addr_i[AW-1:SLOT_BITS];
            ptr_q  <= wr_addr_i[SLOT_BITS-1:0];
        end else if (put) begin
            ptr_q  <= ptr_q + 1'b1;
        end
    end

    pb_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    pb_slot_store #(.SLOT_BITS(SLOT_BITS), .DW(DW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .put_i       (put),
        .put_slot_i  (ptr_q),
        .put_data_i  (wr_data_i),
        .take_i      (take),
        .fill_cnt_o  (fill_cnt),
        .head_slot_o (head_slot),
        .head_data_o (head_data)
    );

    pb_seq_fsm #(.CNT_W(CNT_W), .ROLLING(ROLLING), .LIMIT(LIMIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (wr_start_i),
        .byte_i     (wr_byte_i),
        .prot_i     (wr_prot_i),
        .commit_i   (wr_commit_i),
        .fill_cnt_i (fill_cnt),
        .tick_i     (tick),
        .busy_o     (busy_o),
        .ack_o      (wr_ack_o),
        .ptr_load_o (ptr_load),
        .put_o      (put),
        .take_o     (take),
        .clr_o      (clr)
    );

    assign mem_we_o   = take;
    assign mem_addr_o = {base_q, head_slot};
    assign mem_data_o = head_data;

    // R6: the array is written only inside a program cycle
    assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R7: no acknowledge while the program cycle runs
    assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !wr_ack_o);

    // R5: busy only rises after a commit
    assert_rise_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(wr_commit_i));

    // R7: busy only falls right after a write
    assert_fall_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(mem_we_o));

    // R8: a protected byte is never acknowledged
    assert_prot_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prot_i |-> !wr_ack_o);

    generate
        if (!ROLLING) begin : g_chk_limit
            // R4: an accepted byte always finds room below the limit
            assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_ack_o |-> (fill_cnt < CNT_W'(LIMIT)));
        end
    endgenerate
endmodule

// File: tb/tb_pb_program_seq.sv
`timescale 1ns/1ps
module tb_pb_program_seq;
    localparam int TDIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_start = 0, s_byte = 0, s_prot = 0, s_commit = 0;
    logic [7:0] s_addr = 0, s_data = 0;

    logic       ack1, busy1, we1;
    logic [7:0] addr1, data1;
    logic       ack2, busy2, we2;
    logic [7:0] addr2, data2;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pb_program_seq #(.ROLLING(1'b1), .TICK_DIV(TDIV)) dut (
        .clk(clk), .rst_n(rst_n), .wr_start_i(s_start), .wr_addr_i(s_addr),
        .wr_byte_i(s_byte), .wr_data_i(s_data), .wr_prot_i(s_prot), .wr_commit_i(s_commit),
        .wr_ack_o(ack1), .busy_o(busy1), .mem_we_o(we1), .mem_addr_o(addr1), .mem_data_o(data1));

    pb_program_seq #(.ROLLING(1'b0), .LIMIT(2), .TICK_DIV(TDIV)) dut2 (
        .clk(clk), .rst_n(rst_n), .wr_start_i(s_start), .wr_addr_i(s_addr),
        .wr_byte_i(s_byte), .wr_data_i(s_data), .wr_prot_i(s_prot), .wr_commit_i(s_commit),
        .wr_ack_o(ack2), .busy_o(busy2), .mem_we_o(we2), .mem_addr_o(addr2), .mem_data_o(data2));

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bench memories and monitors
    logic [7:0] mem1 [256];
    logic [7:0] mem2 [256];
    int bc1 = 0, bc2 = 0, wc1 = 0, wc2 = 0;
    int wq1 [$];

    // reference model of the rolling instance
    int  ms = 0, mbase = 0, mptr = 0, mtc = 0;
    int  msd [8];
    bit  msv [8];

    function automatic void mclear();
        for (int i = 0; i < 8; i++) begin msv[i] = 0; msd[i] = 0; end
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            ms = 0; mbase = 0; mptr = 0; mtc = 0; mclear();
        end else begin
            int  lo;
            int  any;
            bit  e_busy, e_ack, e_we;
            lo = -1;
            for (int i = 7; i >= 0; i--) if (msv[i]) lo = i;
            any = 0;
            for (int i = 0; i < 8; i++) if (msv[i]) any++;
            e_busy = (ms == 3);
            e_ack  = (ms == 1) && s_byte && !s_start && !s_commit && !s_prot;
            e_we   = (ms == 3) && (mtc == TDIV - 1);
            chk(busy1 == e_busy && ack1 == e_ack && we1 == e_we &&
                (!e_we || (int'(addr1) == mbase * 8 + lo && int'(data1) == msd[lo])),
                "R6", "cycle model busy/ack/we/addr", {busy1, ack1, we1, addr1},
                {e_busy, e_ack, e_we, 8'(mbase * 8 + (lo < 0 ? 0 : lo))});
            if (ms == 3) begin
                if (e_we) begin
                    msv[lo] = 0;
                    mtc = 0;
                    if (any == 1) begin ms = 0; mclear(); end
                end else mtc++;
            end else if (s_start) begin
                ms = 1; mclear(); mbase = s_addr / 8; mptr = s_addr % 8;
            end else if (s_commit) begin
                if (ms == 1 && any > 0) begin ms = 3; mtc = 0; end
                else begin ms = 0; mclear(); end
            end else if (s_byte && ms == 1) begin
                if (s_prot) begin ms = 2; mclear(); end
                else begin msd[mptr] = s_data; msv[mptr] = 1; mptr = (mptr + 1) % 8; end
            end
            // monitors
            if (busy1) bc1++;
            if (busy2) bc2++;
            if (we1) begin mem1[addr1] = data1; wc1++; wq1.push_back(addr1); end
            if (we2) begin mem2[addr2] = data2; wc2++; end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send_start(input logic [7:0] a);
        s_start = 1; s_addr = a; step(); s_start = 0;
    endtask

    task automatic send_byte(input logic [7:0] d, input logic p, output logic a1, output logic a2);
        s_byte = 1; s_data = d; s_prot = p;
        @(negedge clk); a1 = ack1; a2 = ack2;
        @(posedge clk); #1; s_byte = 0; s_prot = 0;
    endtask

    task automatic send_commit(output logic b_at, output logic b_next);
        s_commit = 1;
        @(negedge clk); b_at = busy1;
        @(posedge clk); #1; s_commit = 0;
        @(negedge clk); b_next = busy1;
        @(posedge clk); #1;
    endtask

    task automatic wait_quiet();
        int n = 0;
        while ((busy1 || busy2) && n < 2000) begin step(); n++; end
        step(); step();
    endtask

    task automatic clear_stats();
        bc1 = 0; bc2 = 0; wc1 = 0; wc2 = 0; wq1.delete();
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a1, a2, b0, b1;
        for (int i = 0; i < 256; i++) begin mem1[i] = 0; mem2[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!busy1 && !ack1 && !we1, "R1", "rolling outputs in reset", {busy1, ack1, we1}, 0);
        chk(!busy2 && !ack2 && !we2, "R1", "limited outputs in reset", {busy2, ack2, we2}, 0);
        @(posedge clk); #1; rst_n = 1;
        step();

        // R11: byte with no open sequence, then commit
        clear_stats();
        send_byte(8'h99, 0, a1, a2);
        chk(!a1 && !a2, "R11", "ack on unopened byte", {a1, a2}, 0);
        send_commit(b0, b1);
        wait_quiet();
        chk(wc1 == 0 && wc2 == 0 && bc1 == 0, "R11", "writes after unopened byte", wc1 + wc2, 0);

        // R9: empty commit
        clear_stats();
        send_start(8'h40);
        send_commit(b0, b1);
        wait_quiet();
        chk(b1 == 0 && bc1 == 0 && bc2 == 0, "R9", "busy after empty commit", bc1 + bc2, 0);

        // R5/R6: single byte write
        clear_stats();
        send_start(8'h40);
        send_byte(8'hA5, 0, a1, a2);
        chk(a1 && a2, "R5", "ack single byte", {a1, a2}, 2'b11);
        send_commit(b0, b1);
        chk(!b0 && b1, "R7", "busy rises after commit", {b0, b1}, 2'b01);
        wait_quiet();
        chk(wc1 == 1 && mem1[8'h40] == 8'hA5, "R5", "single write rolling", mem1[8'h40], 8'hA5);
        chk(wc2 == 1 && mem2[8'h40] == 8'hA5, "R5", "single write limited", mem2[8'h40], 8'hA5);
        chk(bc1 == TDIV, "R6", "busy length one byte", bc1, TDIV);

        // R2/R10 rolling, R4 limited: start near page top
        clear_stats();
        send_start(8'h1E);
        send_byte(8'h11, 0, a1, a2);
        send_byte(8'h22, 0, a1, a2);
        send_byte(8'h33, 0, a1, a2);
        chk(a1 && !a2, "R4", "third byte acks rolling/limited", {a1, a2}, 2'b10);
        send_commit(b0, b1);
        wait_quiet();
        chk(mem1[8'h18] == 8'h33 && mem1[8'h1E] == 8'h11 && mem1[8'h1F] == 8'h22 && mem1[8'h20] == 0,
            "R2", "low bits wrap inside page", mem1[8'h18], 8'h33);
        chk(wq1.size() == 3 && wq1[0] == 8'h18 && wq1[1] == 8'h1E && wq1[2] == 8'h1F,
            "R10", "ascending slot order first addr", wq1.size() > 0 ? wq1[0] : -1, 8'h18);
        chk(bc1 == 3 * TDIV, "R6", "busy length three bytes", bc1, 3 * TDIV);
        chk(wc2 == 0 && bc2 == 0 && mem2[8'h1E] == 0, "R4", "limited overflow aborts", wc2, 0);

        // R3: ten bytes into rolling page
        clear_stats();
        send_start(8'h80);
        for (int k = 0; k < 10; k++) begin
            send_byte(8'hC0 + 8'(k), 0, a1, a2);
            if (k == 2) chk(!a2, "R4", "limited third byte nack", a2, 0);
            if (k == 9) chk(a1, "R3", "rolling tenth byte ack", a1, 1);
        end
        send_commit(b0, b1);
        wait_quiet();
        chk(wc1 == 8, "R3", "rolling write count", wc1, 8);
        chk(mem1[8'h80] == 8'hC8 && mem1[8'h81] == 8'hC9, "R3", "wrapped slots latest data",
            {mem1[8'h80], mem1[8'h81]}, 16'hC8C9);
        for (int i = 2; i < 8; i++)
            chk(mem1[8'h80 + i] == 8'hC0 + 8'(i), "R3", "unwrapped slot data", mem1[8'h80 + i], 8'hC0 + i);
        chk(bc1 == 8 * TDIV, "R6", "busy length full page", bc1, 8 * TDIV);
        chk(wc2 == 0, "R4", "limited no writes after overflow", wc2, 0);

        // R7: start and byte during busy are ignored
        clear_stats();
        send_start(8'h50);
        send_byte(8'h5A, 0, a1, a2);
        send_commit(b0, b1);
        send_start(8'h60);
        send_byte(8'h77, 0, a1, a2);
        chk(!a1 && !a2, "R7", "no ack while busy", {a1, a2}, 0);
        wait_quiet();
        send_commit(b0, b1);
        wait_quiet();
        chk(b1 == 0 && mem1[8'h60] == 0 && wc1 == 1, "R7", "busy-time input ignored", wc1, 1);

        // R8: protection aborts, including earlier bytes
        clear_stats();
        send_start(8'h20);
        send_byte(8'h44, 0, a1, a2);
        send_byte(8'h55, 1, a1, a2);
        chk(!a1 && !a2, "R8", "protected byte nack", {a1, a2}, 0);
        send_commit(b0, b1);
        wait_quiet();
        chk(b1 == 0 && wc1 == 0 && wc2 == 0 && mem1[8'h20] == 0, "R8", "no program after protect", wc1 + wc2, 0);

        // R4: limited mode with exactly two bytes
        clear_stats();
        send_start(8'h33);
        send_byte(8'h01, 0, a1, a2);
        send_byte(8'h02, 0, a1, a2);
        chk(a2, "R4", "limited second byte ack", a2, 1);
        send_commit(b0, b1);
        wait_quiet();
        chk(wc2 == 2 && mem2[8'h33] == 8'h01 && mem2[8'h34] == 8'h02, "R4", "limited two-byte page",
            {mem2[8'h33], mem2[8'h34]}, 16'h0102);
        chk(bc2 == 2 * TDIV, "R6", "limited busy length", bc2, 2 * TDIV);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule